// File: doc/BRIEF.md
# Logistic-Map Chaotic Control-Word Generator

This block produces a pseudo-chaotic stream of 17-bit control words by iterating the logistic map x' = mu·x·(1 − x) in fixed point. The state x is an unsigned 17-bit fraction. The parameter mu has 2 integer bits and 17 fraction bits. A single multiplier is shared across the two multiplications of each iteration. A cipher core next to the block takes one word for every 8-byte group it processes, so the generator only needs to finish one iteration every 8 core cycles.

The block runs on the core clock and advances its arithmetic on an internal clock-enable tick, one core cycle in four. The state machine has three states:

- **IDLE**: no seed has been loaded since reset.
- **MUL_A**: the multiplier forms p = mu·x.
- **MUL_B**: the multiplier forms x' = p·(1 − x).

The transitions are:

- **seed** (IDLE/MUL_A/MUL_B → MUL_A): taken on the load strobe.
- **half** (MUL_A → MUL_B): taken on a tick.
- **emit** (MUL_B → MUL_A): taken on a tick; it writes the new state and presents it as the output word.

The first multiply uses the freshly loaded x(0). Every later iteration uses the previous result.

Top module: `logmap_bitgen`

## Requirements
- R1: After reset, `word_valid` is 0 and `word_out` is 0. Until the first `load`, `word_valid` never rises.
- R2: A `load` pulse captures `mu_in` and `x0_in`. `mu_in[18:17]` holds the integer part and `mu_in[16:0]` the fraction; `x0_in` is a pure 17-bit fraction. `word_valid` is 0 in the cycle after the load.
- R3: The first word appears 8 core cycles after the load edge. Further words follow every 8 core cycles. `word_valid` is high for exactly one core cycle per word.
- R4: Each word follows two truncating steps: p = floor(mu·x / 2^17), kept to 19 bits, then x' = floor(p·(2^17 − x) / 2^17) mod 2^17. `word_out` = x'.
- R5: `word_out` holds its value between `word_valid` pulses.
- R6: Each iteration starts from the previous word, so a sequence of words matches repeated application of R4.
- R7: A seed of x(0) = 0 yields zero words, still paced as in R3.
- R8: A `load` during an iteration discards that iteration. The next word comes from the new seed, 8 cycles after the new load edge.
- R9: Reset asserted during operation returns the outputs to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Seed strobe, one cycle |
| mu_in | input | 19 | Map parameter, 2.17 unsigned fixed point |
| x0_in | input | 17 | Initial state, 0.17 unsigned fraction |
| word_out | output | 17 | Latest 17-bit control word |
| word_valid | output | 1 | One-cycle pulse marking a new word |

## Verification
The bench runs a directed seed near mu = 3.9, x = 0.75 over a long run of words, which exposes errors that accumulate through the fed-back state. Random mu values in [3, 4) with random nonzero seeds exercise the truncation of both products across the operand space. Extreme operands are also tried: mu at its maximum code, x at its maximum code, x = 0, and mu = 0. These separate the (1 − x) term from a plain complement and show whether a zero state is kept. A reload part-way through an iteration and a mid-run reset check that stale partial products are discarded and that the 8-cycle cadence restarts from the new load edge.

// File: rtl/logmap_pkg.sv
package logmap_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_MUL_A = 2'd1,
        S_MUL_B = 2'd2
    } gen_state_t;
endpackage

// File: rtl/logmap_tick.sv
module logmap_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/logmap_mul.sv
module logmap_mul #(
    parameter int FRAC_W = 17,
    parameter int INT_W  = 2
) (
    input  logic                      first_half,
    input  logic [INT_W+FRAC_W-1:0]   mu,
    input  logic [FRAC_W-1:0]         x,
    input  logic [INT_W+FRAC_W-1:0]   partial,
    output logic [INT_W+FRAC_W-1:0]   result
);
    localparam int AW = INT_W + FRAC_W;
    localparam int BW = FRAC_W + 1;
    localparam int PW = AW + BW;
    localparam logic [BW-1:0] ONE = {1'b1, {FRAC_W{1'b0}}};

    logic [AW-1:0] op_a;
    logic [BW-1:0] op_b;
    logic [PW-1:0] full;

    always_comb begin
        if (first_half) begin
            op_a = mu;
            op_b = {1'b0, x};
        end else begin
            op_a = partial;
            op_b = ONE - {1'b0, x};
        end
        full   = PW'(op_a) * PW'(op_b);
        result = full[FRAC_W +: AW];
    end
endmodule

// File: rtl/logmap_bitgen.sv
module logmap_bitgen
    import logmap_pkg::*;
#(
    parameter int FRAC_W = 17,
    parameter int INT_W  = 2,
    parameter int DIV    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [INT_W+FRAC_W-1:0]  mu_in,
    input  logic [FRAC_W-1:0]        x0_in,
    output logic [FRAC_W-1:0]        word_out,
    output logic                     word_valid
);
    localparam int MW = INT_W + FRAC_W;

    gen_state_t       state_q, state_d;
    logic [MW-1:0]    mu_q;
    logic [FRAC_W-1:0] x_q;
    logic [MW-1:0]    part_q;
    logic [MW-1:0]    mul_res;
    logic             tick;

    logmap_tick #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .run     (state_q != S_IDLE),
        .tick    (tick)
    );

    logmap_mul #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_mul (
        .first_half (state_q == S_MUL_A),
        .mu         (mu_q),
        .x          (x_q),
        .partial    (part_q),
        .result     (mul_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = S_MUL_A;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_MUL_A: if (tick) state_d = S_MUL_B;
                S_MUL_B: if (tick) state_d = S_MUL_A;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mu_q       <= '0;
            x_q        <= '0;
            part_q     <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (load) begin
                mu_q   <= mu_in;
                x_q    <= x0_in;
                part_q <= '0;
            end else if (tick) begin
                unique case (state_q)
                    S_MUL_A: part_q <= mul_res;
                    S_MUL_B: begin
                        x_q        <= mul_res[FRAC_W-1:0];
                        word_out   <= mul_res[FRAC_W-1:0];
                        word_valid <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    // R2
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !word_valid);
    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (word_valid || $stable(word_out)));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !word_valid);
    // R3
    valid_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (state_q == S_MUL_A));
endmodule

// File: tb/logmap_bitgen_tb.sv
module logmap_bitgen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [18:0] mu_in = '0;
    logic [16:0] x0_in = '0;
    logic [16:0] word_out;
    logic        word_valid;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    logmap_bitgen u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .mu_in(mu_in),
        .x0_in(x0_in), .word_out(word_out), .word_valid(word_valid)
    );

    function automatic logic [16:0] next_x(logic [18:0] mu, logic [16:0] x);
        longint p, r;
        p = (longint'(mu) * longint'(x)) >> 17;
        p = p & 64'h7FFFF;
        r = (p * (64'd131072 - longint'(x))) >> 17;
        return r[16:0];
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic seed(input logic [18:0] mu, input logic [16:0] x);
        @(negedge clk);
        load = 1'b1; mu_in = mu; x0_in = x;
        @(negedge clk);
        load = 1'b0;
    endtask

    // expects n words; x is the state before the first
    task automatic run_words(input int n, input logic [18:0] mu, input logic [16:0] x0, input string req);
        logic [16:0] x;
        logic [16:0] held;
        bit gap_ok;
        bit val_ok;
        x = x0;
        gap_ok = 1'b1;
        val_ok = 1'b1;
        for (int w = 0; w < n; w++) begin
            held = word_out;
            for (int k = 0; k < 7; k++) begin
                @(negedge clk);
                if (word_valid || word_out != held) gap_ok = 1'b0;
            end
            @(negedge clk);
            x = next_x(mu, x);
            if (!word_valid || word_out != x) begin
                if (val_ok)
                    check(1'b0, req, {word_valid, word_out}, {1'b1, x});
                val_ok = 1'b0;
            end
        end
        check(val_ok, req, 0, 0);
        check(gap_ok, "R3/R5 gap", 0, 0);
    endtask

    initial begin
        bit ok;
        logic [18:0] m;
        logic [16:0] xs;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(word_valid == 1'b0 && word_out == 17'd0, "R1 reset", {word_valid, word_out}, 0);
        rst_n = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (word_valid) ok = 1'b0;
        end
        check(ok, "R1 idle no valid", 0, 0);

        // R2 R3 R4 R6 directed mu~3.9 x=0.75
        seed(19'd511181, 17'd98304);
        check(word_valid == 1'b0, "R2 quiet after load", word_valid, 0);
        run_words(60, 19'd511181, 17'd98304, "R4/R6 directed");

        // R4 random seeds, mu in [3,4)
        for (int t = 0; t < 20; t++) begin
            m  = {2'b11, 17'($urandom)};
            xs = 17'($urandom);
            if (xs == 0) xs = 17'd1;
            seed(m, xs);
            run_words(6, m, xs, "R4 random");
        end

        // R4 extremes
        seed(19'h7FFFF, 17'h1FFFF);
        run_words(4, 19'h7FFFF, 17'h1FFFF, "R4 max operands");
        seed(19'd0, 17'd5000);
        run_words(3, 19'd0, 17'd5000, "R4 mu zero");
        // R7 zero seed
        seed(19'd480000, 17'd0);
        run_words(5, 19'd480000, 17'd0, "R7 zero seed");

        // R8 reload mid-iteration
        seed(19'd450000, 17'd30000);
        ok = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (word_valid) ok = 1'b0;
        end
        check(ok, "R8 no word before reload", 0, 0);
        seed(19'd500000, 17'd77777);
        run_words(4, 19'd500000, 17'd77777, "R8 reload");

        // R9 mid-run reset
        seed(19'd470000, 17'd12345);
        repeat (11) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(word_valid == 1'b0 && word_out == 17'd0, "R9 reset mid-run", {word_valid, word_out}, 0);
        rst_n = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (word_valid) ok = 1'b0;
        end
        check(ok, "R9 idle after reset", 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule